// File: doc/BRIEF.md
# 10BASE-T Transmit Jabber and Heartbeat Supervisor

This block sits beside the 10 Mb/s transmit path and watches the transmit-enable strobe from the MAC. It has two jobs. If a frame runs far too long, it closes the transmit gate and raises a jabber flag. The gate then stays closed until the line has been quiet for an unbroken recovery interval. After a frame that ends normally, it sends the MAC a short collision-test pulse (the heartbeat, or SQE test), provided the heartbeat is enabled.

All intervals are counted in cycles of the block clock. By default they derive from a `CLK_HZ` parameter (25 MHz):

| Interval | Default |
|---|---|
| Jabber trip | 85 ms |
| Recovery quiet period | 500 ms |
| Heartbeat delay | 1200 ns |
| Heartbeat width | 1000 ns |

Each interval can be overridden directly in cycles. The same heartbeat behaviour applies whichever 10 Mb/s interface mode the surrounding logic uses.

One state machine drives the block, and its outputs are decoded from the state register. The states are:

- `ST_IDLE`: gate open.
- `ST_SEND`: frame in progress, gate open.
- `ST_HBWAIT`: counting the heartbeat delay.
- `ST_HBON`: heartbeat pulse high.
- `ST_JAB`: gate closed, jabber flag set.

The transitions are:

- IDLE→SEND when tx_en is sampled high.
- SEND→JAB on the trip count.
- SEND→HBWAIT when tx_en is sampled low and sqe_en is high.
- SEND→IDLE when tx_en is sampled low and sqe_en is low.
- HBWAIT→HBON when the delay expires.
- HBWAIT→SEND and HBON→SEND when tx_en is sampled high.
- HBON→IDLE when the width expires.
- JAB→IDLE after the recovery count.

A single shared interval counter restarts on every state change. In `ST_JAB` it also restarts on every cycle with tx_en high.

Top module: `tx_jabber_guard`

## Requirements
- R1: A synchronous reset, including one applied while jabbering, leaves tx_gate=1, jabber=0 and sqe=0 after the reset edge.
- R2: Counting the clock edges that sample tx_en high in an unbroken run, jabber rises after the edge that samples high for the JAB_CYC-th time, and not before.
- R3: tx_gate is 0 exactly while jabber is 1, at every cycle.
- R4: Once jabbering, the gate reopens after the edge that samples tx_en low for the UNJAB_CYC-th consecutive time. Any edge sampling tx_en high during the quiet period restarts that count.
- R5: A frame ended by a jabber cutoff produces no heartbeat, either during the jabber or after recovery.
- R6: For a normal frame with sqe_en=1, let edge e0 be the first edge that samples tx_en low. sqe stays 0 after edges e0 to e0+HB_DLY_CYC-1 and rises after edge e0+HB_DLY_CYC.
- R7: The heartbeat pulse stays high for exactly HB_LEN_CYC cycles and then returns to 0.
- R8: If sqe_en is 0 on edge e0, that frame produces no heartbeat.
- R9: If tx_en is sampled high during the heartbeat delay or the pulse, the heartbeat is abandoned: sqe is 0 after that edge, the gate stays open, and a new frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable from the MAC |
| sqe_en | input | 1 | 1 enables the post-frame heartbeat |
| tx_gate | output | 1 | 1 lets the transmitter drive the line |
| jabber | output | 1 | Jabber status, high while the gate is closed |
| sqe | output | 1 | Heartbeat collision-test indication to the MAC |

## Verification
The hardest case to reach is the restart of the recovery count.

- Stimulus sequence: the bench first jabs the gate shut, then idles for all but three cycles of the quiet period, then briefly reasserts tx_en.
- What is checked: the gate must stay closed for a full fresh quiet interval measured from that reassertion.
- Scale: this runs at several overrun lengths in a small cycle configuration.

A second hard case is an abandoned heartbeat. The bench cuts a normal frame's trailing idle at every offset through the delay and the pulse, then checks that the next frame still gets a correctly timed heartbeat.

// File: rtl/jg_pkg.sv
package jg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEND   = 3'd1,
        ST_HBWAIT = 3'd2,
        ST_HBON   = 3'd3,
        ST_JAB    = 3'd4
    } guard_st_e;

endpackage

// File: rtl/jg_interval_ctr.sv
module jg_interval_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         step,
    output logic [W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/jg_ctrl.sv
module jg_ctrl
    import jg_pkg::*;
#(
    parameter int W          = 8,
    parameter int JAB_CYC    = 20,
    parameter int UNJAB_CYC  = 30,
    parameter int HB_DLY_CYC = 5,
    parameter int HB_LEN_CYC = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tx_en,
    input  logic         sqe_en,
    input  logic [W-1:0] count,
    output logic         restart,
    output logic         step,
    output logic         tx_gate,
    output logic         jabber,
    output logic         sqe
);

    // Count values seen on the edge that completes each interval.
    localparam logic [W-1:0] JAB_AT   = W'(JAB_CYC - 2);
    localparam logic [W-1:0] UNJAB_AT = W'(UNJAB_CYC - 1);
    localparam logic [W-1:0] HBD_AT   = W'(HB_DLY_CYC - 1);
    localparam logic [W-1:0] HBL_AT   = W'(HB_LEN_CYC - 1);

    guard_st_e st, nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (tx_en) nxt = ST_SEND;
            end
            ST_SEND: begin
                if (!tx_en)               nxt = sqe_en ? ST_HBWAIT : ST_IDLE;
                else if (count == JAB_AT) nxt = ST_JAB;
            end
            ST_HBWAIT: begin
                if (tx_en)                nxt = ST_SEND;
                else if (count == HBD_AT) nxt = ST_HBON;
            end
            ST_HBON: begin
                if (tx_en)                nxt = ST_SEND;
                else if (count == HBL_AT) nxt = ST_IDLE;
            end
            ST_JAB: begin
                if (!tx_en && count == UNJAB_AT) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        restart = (nxt != st) || (st == ST_JAB && tx_en);
        step    = (st != ST_IDLE);
    end

    always_comb begin
        tx_gate = 1'b1;
        jabber  = 1'b0;
        sqe     = 1'b0;
        unique case (st)
            ST_IDLE, ST_SEND, ST_HBWAIT: ;
            ST_HBON: sqe = 1'b1;
            ST_JAB: begin
                tx_gate = 1'b0;
                jabber  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/tx_jabber_guard.sv
module tx_jabber_guard #(
    parameter int CLK_HZ     = 25_000_000,
    parameter int JAB_CYC    = (CLK_HZ / 1000) * 85,
    parameter int UNJAB_CYC  = (CLK_HZ / 1000) * 500,
    parameter int HB_DLY_CYC = ((CLK_HZ / 1_000_000) * 12) / 10,
    parameter int HB_LEN_CYC = CLK_HZ / 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic tx_en,
    input  logic sqe_en,
    output logic tx_gate,
    output logic jabber,
    output logic sqe
);

    localparam int LONG_A  = (JAB_CYC > UNJAB_CYC) ? JAB_CYC : UNJAB_CYC;
    localparam int LONG_B  = (HB_DLY_CYC > HB_LEN_CYC) ? HB_DLY_CYC : HB_LEN_CYC;
    localparam int LONGEST = (LONG_A > LONG_B) ? LONG_A : LONG_B;
    localparam int CNT_W   = $clog2(LONGEST + 1);

    logic [CNT_W-1:0] count;
    logic             restart;
    logic             step;

    jg_interval_ctr #(.W(CNT_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .step    (step),
        .count   (count)
    );

    jg_ctrl #(
        .W          (CNT_W),
        .JAB_CYC    (JAB_CYC),
        .UNJAB_CYC  (UNJAB_CYC),
        .HB_DLY_CYC (HB_DLY_CYC),
        .HB_LEN_CYC (HB_LEN_CYC)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .sqe_en  (sqe_en),
        .count   (count),
        .restart (restart),
        .step    (step),
        .tx_gate (tx_gate),
        .jabber  (jabber),
        .sqe     (sqe)
    );

endmodule

// File: rtl/jg_checks.sv
module jg_checks #(
    parameter int HB_LEN_CYC = 4
) (
    input logic clk,
    input logic rst,
    input logic tx_en,
    input logic tx_gate,
    input logic jabber,
    input logic sqe
);

    logic        rst_q;
    logic [31:0] hb_run;

    always_ff @(posedge clk) begin
        rst_q <= rst;
        if (rst) begin
            hb_run <= '0;
        end else if (sqe) begin
            hb_run <= hb_run + 1;
        end else begin
            hb_run <= '0;
        end
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_q) begin
            reset_idle_chk: assert (tx_gate && !jabber && !sqe);
        end
    end

    // R3
    gate_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        tx_gate != jabber);

    // R2
    jab_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(jabber) |-> $past(tx_en));

    // R4
    jab_fall_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(jabber) && !$past(rst)) |-> !$past(tx_en));

    // R6
    hb_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sqe) |-> (!$past(tx_en) && !jabber));

    // R7
    hb_width_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(sqe) && !$past(rst) && !$past(tx_en)) |-> (hb_run == HB_LEN_CYC));

endmodule

bind tx_jabber_guard jg_checks #(.HB_LEN_CYC(HB_LEN_CYC)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tx_en   (tx_en),
    .tx_gate (tx_gate),
    .jabber  (jabber),
    .sqe     (sqe)
);

// File: tb/sim_tx_jabber_guard.sv
`timescale 1ns/1ps
module sim_tx_jabber_guard;

    localparam int PERIOD = 10;
    localparam int JAB    = 20;
    localparam int UNJAB  = 30;
    localparam int DLY    = 5;
    localparam int LEN    = 4;

    logic clk = 1'b0;
    logic rst;
    logic tx_en;
    logic sqe_en;
    logic tx_gate;
    logic jabber;
    logic sqe;

    int errors = 0;
    int checks = 0;

    always #(PERIOD / 2) clk = ~clk;

    tx_jabber_guard #(
        .CLK_HZ     (1_000_000),
        .JAB_CYC    (JAB),
        .UNJAB_CYC  (UNJAB),
        .HB_DLY_CYC (DLY),
        .HB_LEN_CYC (LEN)
    ) u0 (
        .clk     (clk),
        .rst     (rst),
        .tx_en   (tx_en),
        .sqe_en  (sqe_en),
        .tx_gate (tx_gate),
        .jabber  (jabber),
        .sqe     (sqe)
    );

    task automatic obs(input string req, input logic g_e, input logic j_e, input logic s_e);
        checks++;
        if (tx_gate !== g_e || jabber !== j_e || sqe !== s_e) begin
            errors++;
            $display("FAIL %s t=%0t gate/jabber/sqe act=%b%b%b exp=%b%b%b",
                     req, $time, tx_gate, jabber, sqe, g_e, j_e, s_e);
        end
    endtask

    // Drive tx_en for the next edge, then sample a quarter period after it.
    task automatic tick(input logic en);
        @(negedge clk);
        tx_en = en;
        @(posedge clk);
        #(PERIOD / 4);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        tx_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #(PERIOD / 4);
        obs("R1", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Idle after a normal frame; j counts edges from e0.
    task automatic tail(input logic h, input int n);
        for (int j = 0; j < n; j++) begin
            logic e;
            tick(1'b0);
            e = h && (j >= DLY) && (j < DLY + LEN);
            if (!h)           obs("R8", 1'b1, 1'b0, 1'b0);
            else if (j < DLY) obs("R6", 1'b1, 1'b0, e);
            else              obs("R7", 1'b1, 1'b0, e);
        end
    endtask

    task automatic run_frame(input int len, input logic h);
        sqe_en = h;
        for (int i = 1; i <= len; i++) begin
            tick(1'b1);
            obs("R2", 1'b1, 1'b0, 1'b0);
        end
        tail(h, DLY + LEN + 2);
    endtask

    task automatic run_jab(input int extra);
        sqe_en = 1'b1;
        for (int i = 1; i <= JAB + extra; i++) begin
            logic jb;
            tick(1'b1);
            jb = (i >= JAB);
            obs("R2", !jb, jb, 1'b0);
        end
        for (int q = 1; q <= UNJAB - 3; q++) begin
            tick(1'b0);
            obs("R5", 1'b0, 1'b1, 1'b0);
        end
        tick(1'b1);
        obs("R4", 1'b0, 1'b1, 1'b0);
        tick(1'b1);
        obs("R4", 1'b0, 1'b1, 1'b0);
        for (int q = 1; q <= UNJAB + DLY + LEN + 2; q++) begin
            logic jb;
            tick(1'b0);
            jb = (q < UNJAB);
            if (jb) obs("R4", 1'b0, 1'b1, 1'b0);
            else    obs("R5", 1'b1, 1'b0, 1'b0);
        end
    endtask

    task automatic run_abort(input int k);
        sqe_en = 1'b1;
        for (int i = 0; i < 4; i++) tick(1'b1);
        tail(1'b1, k);
        tick(1'b1);
        obs("R9", 1'b1, 1'b0, 1'b0);
        tick(1'b1);
        obs("R9", 1'b1, 1'b0, 1'b0);
        tail(1'b1, DLY + LEN + 2);
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete (all requirements)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst    = 1'b1;
        tx_en  = 1'b0;
        sqe_en = 1'b1;
        do_reset();

        // R6 R7 R8: every frame length below the trip, heartbeat on and off
        for (int len = 1; len < JAB; len++) begin
            run_frame(len, 1'b1);
            run_frame(len, 1'b0);
        end

        // R2 R3 R4 R5: trip at exactly JAB and beyond, with quiet restart
        for (int x = 0; x < 4; x++) run_jab(x);

        // R9: abandon heartbeat at every offset in delay and pulse
        for (int k = 1; k < DLY + LEN; k++) run_abort(k);

        // R1: reset while jabbering
        sqe_en = 1'b1;
        for (int i = 0; i < JAB + 2; i++) tick(1'b1);
        obs("R3", 1'b0, 1'b1, 1'b0);
        do_reset();
        tick(1'b0);
        obs("R1", 1'b1, 1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule